// File: doc/BRIEF.md
# Converter Convert-Pulse and Burst-Clock Sequencer

This block runs on a fast system clock and drives a successive-approximation converter. Each sample period it raises a convert command, holds the conversion clock low for a programmed guard interval, and then issues a burst of exactly nineteen conversion-clock pulses. After the nineteenth pulse the clock stays low until the next convert command. The sample period, the convert pulse width and the guard length are given in system-clock ticks. A one-bit select picks a high time of one third or one half of the fixed conversion-clock period. A one-cycle frame strobe marks the nineteenth rising edge.

The settings are checked at each period boundary. A setting is rejected, with an error flag and no start, in four cases: a zero width, a zero guard, a convert pulse that would not end a minimum lead before the nineteenth rising edge, or a burst that does not fit in the period. New settings and the enable are sampled only at a period boundary, or while idle. A running period always completes with the settings it started with.

The controller has four states. ST_IDLE moves to ST_GUARD on launch, which needs enable high and a valid setting. ST_GUARD moves to ST_BURST when the guard count expires. ST_BURST moves to ST_REST when the burst is done. From any active state, the last tick of the period moves to ST_GUARD if a new launch is possible and to ST_IDLE if it is not.

Top module: `adc_conv_sequencer`

## Requirements
- R1: After reset, and while enable is low in idle, cnv_o, sclk_o, frame_o and cfg_err_o are all 0.
- R2: With tick t=0 as the first cycle cnv_o is high, cnv_o is high exactly for t < width_i. cnv_o first rises in the cycle after the edge that samples enable high with a valid setting. In continuous running, successive cnv_o rising edges are exactly period_i cycles apart.
- R3: Each period has exactly 19 rising edges on sclk_o. sclk_o stays low from the end of the nineteenth pulse to the next convert.
- R4: The first sclk_o rising edge falls at t = guard_i. sclk_o is low for every t < guard_i.
- R5: The conversion clock has a period of SCLK_DIV ticks (default 6). Its high time is SCLK_DIV/3 ticks when half_duty_i=0 and SCLK_DIV/2 ticks when half_duty_i=1. Rising edge k (k=0..18) is at t = guard_i + k*SCLK_DIV.
- R6: frame_o is high for exactly one cycle per period, at t = guard_i + 18*SCLK_DIV, in the same cycle as the nineteenth sclk_o high.
- R7: A setting is invalid if any of these holds: width_i=0; guard_i=0; width_i + LEAD_TICKS (default 7) > guard_i + 18*SCLK_DIV; or guard_i + 19*SCLK_DIV > period_i. When a launch is attempted with an invalid setting, cfg_err_o is 1 from the next cycle and no convert starts. A later valid launch clears cfg_err_o.
- R8: Input changes made during a period take effect only in the next period. A period in which enable falls still completes, after which outputs stay idle.
- R9: A setting with period_i = guard_i + 19*SCLK_DIV and width_i at its largest legal value runs back to back with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable, sampled at period boundaries |
| period_i | input | CW | Sample period in ticks |
| width_i | input | CW | Convert pulse width in ticks |
| guard_i | input | CW | Clock-free ticks from convert rise to first clock rise |
| half_duty_i | input | 1 | 1: half-period clock high time, 0: one-third |
| cnv_o | output | 1 | Convert command |
| sclk_o | output | 1 | Conversion clock |
| frame_o | output | 1 | One-cycle strobe at the nineteenth clock rise |
| cfg_err_o | output | 1 | Last launch attempt had an invalid setting |

## Verification
Launch takes effect one edge after enable and a valid setting are sampled, so the bench expects cnv_o high at the first falling edge after it drives them. It then predicts every output for each tick t of the period from guard, width, duty and period alone. cfg_err_o is due one edge after a launch attempt, and the bench checks it at the next falling edge. A setting changed mid-period is expected only from the first tick of the following period. Every output is sampled on falling edges, half a cycle from any register update.

// File: rtl/adcs_pkg.sv
package adcs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GUARD,
        ST_BURST,
        ST_REST
    } seq_state_t;

    localparam int unsigned NUM_EDGES = 19;
endpackage

// File: rtl/adcs_cfg_check.sv
module adcs_cfg_check #(
    parameter int CW        = 16,
    parameter int SCLK_DIV  = 6,
    parameter int LEAD      = 7,
    parameter int EDGES     = 19
) (
    input  logic [CW-1:0] per_i,
    input  logic [CW-1:0] wid_i,
    input  logic [CW-1:0] grd_i,
    output logic          ok_o
);
    localparam int XW = CW + 8;

    logic [XW-1:0] last_rise;
    logic [XW-1:0] burst_end;

    always_comb begin
        last_rise = XW'(grd_i) + XW'((EDGES - 1) * SCLK_DIV);
        burst_end = last_rise + XW'(SCLK_DIV);
        ok_o = (|wid_i) && (|grd_i)
            && ((XW'(wid_i) + XW'(LEAD)) <= last_rise)
            && (burst_end <= XW'(per_i));
    end
endmodule

// File: rtl/adcs_burst_clock.sv
module adcs_burst_clock #(
    parameter int SCLK_DIV = 6,
    parameter int EDGES    = 19
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic half_i,
    output logic sclk_o,
    output logic last_rise_o,
    output logic done_o
);
    localparam int PW = $clog2(SCLK_DIV);
    localparam int NW = $clog2(EDGES);
    localparam logic [PW-1:0] PH_LAST = PW'(SCLK_DIV - 1);
    localparam logic [PW-1:0] HI_THIRD = PW'(SCLK_DIV / 3);
    localparam logic [PW-1:0] HI_HALF  = PW'(SCLK_DIV / 2);
    localparam logic [NW-1:0] N_LAST   = NW'(EDGES - 1);

    logic          run_q;
    logic [PW-1:0] ph_q;
    logic [NW-1:0] n_q;
    logic [PW-1:0] hi_ticks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            ph_q  <= '0;
            n_q   <= '0;
        end else if (start_i) begin
            run_q <= 1'b1;
            ph_q  <= '0;
            n_q   <= '0;
        end else if (run_q) begin
            if (ph_q == PH_LAST) begin
                ph_q <= '0;
                if (n_q == N_LAST) begin
                    run_q <= 1'b0;
                end else begin
                    n_q <= n_q + 1'b1;
                end
            end else begin
                ph_q <= ph_q + 1'b1;
            end
        end
    end

    always_comb begin
        hi_ticks    = half_i ? HI_HALF : HI_THIRD;
        sclk_o      = run_q && (ph_q < hi_ticks);
        last_rise_o = run_q && (ph_q == '0) && (n_q == N_LAST);
        done_o      = run_q && (ph_q == PH_LAST) && (n_q == N_LAST);
    end

    p_no_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !run_q);
    p_done_ends_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !sclk_o);
endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer
    import adcs_pkg::*;
#(
    parameter int CW         = 16,
    parameter int SCLK_DIV   = 6,
    parameter int LEAD_TICKS = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] period_i,
    input  logic [CW-1:0] width_i,
    input  logic [CW-1:0] guard_i,
    input  logic          half_duty_i,
    output logic          cnv_o,
    output logic          sclk_o,
    output logic          frame_o,
    output logic          cfg_err_o
);
    seq_state_t    state_q, state_d;
    logic [CW-1:0] t_q, per_q, wid_q, grd_q;
    logic          half_q;
    logic          err_q;
    logic          cfg_ok;
    logic          period_end;
    logic          launch;
    logic          burst_start;
    logic          burst_done;

    adcs_cfg_check #(
        .CW(CW), .SCLK_DIV(SCLK_DIV), .LEAD(LEAD_TICKS), .EDGES(NUM_EDGES)
    ) u_chk (
        .per_i(period_i), .wid_i(width_i), .grd_i(guard_i), .ok_o(cfg_ok)
    );

    adcs_burst_clock #(
        .SCLK_DIV(SCLK_DIV), .EDGES(NUM_EDGES)
    ) u_bclk (
        .clk(clk), .rst_n(rst_n), .start_i(burst_start), .half_i(half_q),
        .sclk_o(sclk_o), .last_rise_o(frame_o), .done_o(burst_done)
    );

    always_comb begin
        period_end = (state_q != ST_IDLE) && (t_q == per_q - 1'b1);
        launch     = en && cfg_ok && ((state_q == ST_IDLE) || period_end);
    end

    // next state
    always_comb begin
        state_d     = state_q;
        burst_start = 1'b0;
        unique case (state_q)
            ST_IDLE:  if (launch) state_d = ST_GUARD;
            ST_GUARD: if (t_q == grd_q - 1'b1) begin
                          state_d     = ST_BURST;
                          burst_start = 1'b1;
                      end
            ST_BURST: if (burst_done) state_d = ST_REST;
            ST_REST:  state_d = ST_REST;
            default:  state_d = ST_IDLE;
        endcase
        if (period_end) state_d = launch ? ST_GUARD : ST_IDLE;
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            t_q     <= '0;
            per_q   <= '0;
            wid_q   <= '0;
            grd_q   <= '0;
            half_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (launch) begin
                t_q    <= '0;
                per_q  <= period_i;
                wid_q  <= width_i;
                grd_q  <= guard_i;
                half_q <= half_duty_i;
            end else if (state_q != ST_IDLE) begin
                t_q <= t_q + 1'b1;
            end
            if ((state_q == ST_IDLE) || period_end) begin
                err_q <= en && !cfg_ok;
            end
        end
    end

    // outputs
    always_comb begin
        cnv_o     = (state_q != ST_IDLE) && (t_q < wid_q);
        cfg_err_o = err_q;
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!sclk_o && !frame_o));
    p_cnv_ends_before_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_o |-> !cnv_o);
    p_guard_clock_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GUARD) |-> !sclk_o);
    p_frame_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_o |=> !frame_o);
    p_err_blocks_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> (state_q == ST_IDLE));
    p_tick_in_period_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (t_q < per_q));
endmodule

// File: tb/tb_adc_conv_sequencer.sv
`timescale 1ns/1ps
module tb_adc_conv_sequencer;
    localparam int DIV  = 6;
    localparam int LEAD = 7;

    typedef struct {
        int p;
        int w;
        int g;
        bit s;
    } cfg_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [15:0] period_i = '0, width_i = '0, guard_i = '0;
    logic half_duty_i = 1'b0;
    logic cnv_o, sclk_o, frame_o, cfg_err_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    adc_conv_sequencer dut (
        .clk(clk), .rst_n(rst_n), .en(en), .period_i(period_i),
        .width_i(width_i), .guard_i(guard_i), .half_duty_i(half_duty_i),
        .cnv_o(cnv_o), .sclk_o(sclk_o), .frame_o(frame_o), .cfg_err_o(cfg_err_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic put(input cfg_t c);
        period_i    = c.p[15:0];
        width_i     = c.w[15:0];
        guard_i     = c.g[15:0];
        half_duty_i = c.s;
    endtask

    function automatic bit exp_sclk(input cfg_t c, input int t);
        int hi = c.s ? DIV / 2 : DIV / 3;
        return (t >= c.g) && (t < c.g + 19 * DIV) && (((t - c.g) % DIV) < hi);
    endfunction

    function automatic cfg_t rnd_cfg();
        cfg_t c;
        int span;
        c.g  = 1 + int'($urandom % 20);
        c.s  = bit'($urandom % 2);
        span = c.g + 18 * DIV;
        c.w  = 1 + int'($urandom % (span - LEAD));
        c.p  = span + DIV + int'($urandom % 40);
        return c;
    endfunction

    // Called at the falling edge of tick 0; returns at tick 0 of the next period.
    task automatic run_periods(input cfg_t c, input int nper, input bit swap,
                               input cfg_t nxt, input bit en_after);
        for (int p = 0; p < nper; p++) begin
            int mc = 0, ms = 0, mf = 0, rises = 0, first = -1, fcnt = 0;
            bit prev = 1'b0;
            for (int t = 0; t < c.p; t++) begin
                if (cnv_o !== (t < c.w)) mc++;
                if (sclk_o !== exp_sclk(c, t)) ms++;
                if (frame_o !== (t == c.g + 18 * DIV)) mf++;
                if (frame_o === 1'b1) fcnt++;
                if (sclk_o === 1'b1 && !prev) begin
                    rises++;
                    if (first < 0) first = t;
                end
                prev = (sclk_o === 1'b1);
                if (swap && p == nper - 1 && t == c.p / 2) begin
                    put(nxt);
                    en = en_after;
                end
                @(negedge clk);
            end
            check(mc == 0, "R2 cnv width/spacing mismatches", mc, 0);
            check(rises == 19, "R3 sclk rising edges per period", rises, 19);
            check(first == c.g, "R4 first sclk rise tick", first, c.g);
            check(ms == 0, "R5 sclk waveform mismatches", ms, 0);
            check(mf == 0 && fcnt == 1, "R6 frame strobe count", fcnt, 1);
        end
    endtask

    task automatic quiet(input int n, input string tag);
        int m = 0;
        for (int i = 0; i < n; i++) begin
            if (cnv_o !== 1'b0 || sclk_o !== 1'b0 || frame_o !== 1'b0) m++;
            @(negedge clk);
        end
        check(m == 0, tag, m, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cfg_t a, b, cf, cur, nx, badc;
        void'($urandom(32'd20240611));

        // R1 reset state
        repeat (3) @(negedge clk);
        check({cnv_o, sclk_o, frame_o, cfg_err_o} == 4'b0, "R1 outputs in reset",
              {cnv_o, sclk_o, frame_o, cfg_err_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        quiet(10, "R1 idle with enable low");
        check(cfg_err_o == 1'b0, "R1 error flag idle", cfg_err_o, 0);

        // R7 invalid settings
        a = '{p: 200, w: 10, g: 8, s: 1'b0};
        for (int k = 0; k < 4; k++) begin
            badc = a;
            case (k)
                0: badc.w = 0;
                1: badc.g = 0;
                2: badc.w = badc.g + 18 * DIV - LEAD + 1;
                default: badc.p = badc.g + 19 * DIV - 1;
            endcase
            put(badc);
            en = 1'b1;
            @(negedge clk);
            check(cfg_err_o == 1'b1, "R7 error flag on invalid setting", cfg_err_o, 1);
            quiet(20, "R7 no convert with invalid setting");
        end

        // valid launch clears the error; A then B with mid-period change
        put(a);
        @(negedge clk);
        check(cfg_err_o == 1'b0, "R7 error cleared by valid launch", cfg_err_o, 0);
        check(cnv_o == 1'b1, "R2 convert rises one cycle after launch", cnv_o, 1);
        b = '{p: 180, w: 12, g: 5, s: 1'b1};
        run_periods(a, 2, 1'b1, b, 1'b1);
        // R8: B starts only at the boundary
        cf = '{p: 4 + 19 * DIV, w: 4 + 18 * DIV - LEAD, g: 4, s: 1'b0};
        run_periods(b, 2, 1'b1, cf, 1'b1);
        // R9 exact fit, largest legal width
        cur = cf;
        nx = rnd_cfg();
        run_periods(cur, 3, 1'b1, nx, 1'b1);
        cur = nx;

        // random settings, chained through mid-period changes
        for (int r = 0; r < 8; r++) begin
            nx = rnd_cfg();
            run_periods(cur, 2, 1'b1, nx, 1'b1);
            cur = nx;
        end

        // R8 enable falls mid-period: period completes, then idle
        run_periods(cur, 1, 1'b1, cur, 1'b0);
        quiet(2 * cur.p, "R8 idle after enable drop");

        // R7 invalid setting applied mid-period: period completes, no restart
        en = 1'b1;
        put(a);
        @(negedge clk);
        badc = a;
        badc.g = 0;
        run_periods(a, 1, 1'b1, badc, 1'b1);
        check(cfg_err_o == 1'b1, "R7 error at boundary with invalid setting", cfg_err_o, 1);
        quiet(50, "R7 no restart after invalid boundary setting");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule